// File: doc/BRIEF.md
# Dual-Channel LCD Segment/Common Driver

This block is a synchronous model of a 40-output liquid crystal panel driver built from two identical 20-stage channels. Each channel holds a bidirectional serial shift register feeding a parallel latch of the same width. The latched bits, together with the frame alternation input, choose one of six bias rails for every panel output. The result is a 3-bit rail code per output; the analog levels themselves are generated elsewhere.

A display controller supplies a shift strobe, a latch strobe and the alternation signal. All of these run far slower than the system clock. They are passed through multi-flop synchronisers and edge detectors, so every state change happens on the system clock.

A row-mode input changes the role of channel 2. In row mode, channel 2 shifts on the rising edge of the latch strobe and latches on the rising edge of the shift strobe. It also inverts its alternation input. A frame marker fed in serially therefore walks down the channel once per line, and the channel acts as a row-scan driver. Channel 1 always acts as a column driver.

Each channel's serial data pins are modelled as separate in/out/enable signals, so several blocks can be chained.

Top module: `lcd_segcom_drv`

## Requirements
- R1: While `rst` is high, every shift stage and every latch bit is cleared to zero. With the alternation input low and row mode off, every channel 1 output then reads rail code 4 and every channel 2 output reads rail code 6.
- R2: Stage 0 of each channel sits next to its left serial pin and drives output 1 (channel 1) or output 21 (channel 2). With the channel's `dir_i` bit at 1, data enters at the right pin and moves toward stage 0; with it at 0, data enters at the left pin and moves toward the last stage.
- R3: Channel 1 shifts once per falling edge of `cl2_i` and copies its shift register into its latch once per falling edge of `cl1_i`.
- R4: With `row_mode_i` low, channel 2 uses the same strobe edges as channel 1.
- R5: With `row_mode_i` high, channel 2 shifts once per rising edge of `cl1_i` and latches once per rising edge of `cl2_i`.
- R6: A channel 1 output whose latch bit is 1 reads code 1 when the alternation level is 1 and code 2 when it is 0. A channel 1 output whose latch bit is 0 reads code 3 when the alternation level is 1 and code 4 when it is 0. Code n names rail Vn, and this mapping does not depend on row mode.
- R7: With row mode off, a channel 2 output reads code 1 or 2 for a set bit (alternation 1 or 0). For a clear bit it reads code 5 or 6 (alternation 1 or 0).
- R8: With row mode on, channel 2 sees the inverted alternation level. A set bit then reads code 2 or 1 (alternation 1 or 0), and a clear bit reads code 6 or 5 (alternation 1 or 0).
- R9: A strobe edge presented before system clock edge k takes effect in the register updated at edge k+2. A change of `alt_i` before edge k reaches the rail outputs after edge k+1.
- R10: The serial output on the exit pin of each channel is the last stage in the active direction: stage 0 on the left pin, the final stage on the right pin. Only that pin's output enable is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than every strobe |
| rst | input | 1 | Active-high synchronous reset |
| cl1_i | input | 1 | Latch strobe (also the row-mode shift strobe of channel 2) |
| cl2_i | input | 1 | Shift strobe (also the row-mode latch strobe of channel 2) |
| alt_i | input | 1 | Frame alternation level |
| row_mode_i | input | 1 | 1: channel 2 acts as a row-scan driver |
| dir_i | input | 2 | Per-channel shift direction, bit 0 for channel 1 |
| ser_l_i | input | 2 | Serial input at each channel's left pin |
| ser_r_i | input | 2 | Serial input at each channel's right pin |
| ser_l_o | output | 2 | Serial output at the left pin |
| ser_r_o | output | 2 | Serial output at the right pin |
| ser_l_oe | output | 2 | Left pin drive enable |
| ser_r_oe | output | 2 | Right pin drive enable |
| rail_o | output | 120 | Rail code per output; output i+1 at bits [3i+2:3i] |

## Verification
Strobes, serial data and the alternation level all pass through the same two-flop synchroniser, and an edge detector follows it. A strobe edge set up before clock edge k therefore changes a shift register or latch at edge k+2. The alternation level reaches the rail codes after edge k+1.

The bench holds its own history of the inputs as they stood at each rising edge. It applies every strobe to its behavioural register model two edges late and the alternation level one edge late. It compares rail codes and serial pins at each falling edge, away from any update.

A directed check flips the alternation level. It confirms the output code still holds one edge later and has changed two edges later.

// File: rtl/lcd_drv_pkg.sv
package lcd_drv_pkg;
   localparam int RAIL_W = 3;
   typedef logic [RAIL_W-1:0] rail_t;

   localparam rail_t RAIL_V1 = 3'd1;
   localparam rail_t RAIL_V2 = 3'd2;
   localparam rail_t RAIL_V3 = 3'd3;
   localparam rail_t RAIL_V4 = 3'd4;
   localparam rail_t RAIL_V5 = 3'd5;
   localparam rail_t RAIL_V6 = 3'd6;

   // select rails are shared; each bank has its own non-select pair
   function automatic rail_t pick_rail(input logic on, input logic m_eff, input logic bank2);
      if (on)
         return m_eff ? RAIL_V1 : RAIL_V2;
      else if (bank2)
         return m_eff ? RAIL_V5 : RAIL_V6;
      else
         return m_eff ? RAIL_V3 : RAIL_V4;
   endfunction
endpackage

// File: rtl/lcd_sync_edge.sv
module lcd_sync_edge #(
   parameter int WIDTH = 7,
   parameter int DEPTH = 2
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q,
   output logic [WIDTH-1:0] rise,
   output logic [WIDTH-1:0] fall
);
   logic [WIDTH-1:0] pipe [DEPTH];
   logic [WIDTH-1:0] prev;

   always_ff @(posedge clk) begin
      if (rst) begin
         for (int k = 0; k < DEPTH; k++) pipe[k] <= '0;
         prev <= '0;
      end else begin
         pipe[0] <= d;
         for (int k = 1; k < DEPTH; k++) pipe[k] <= pipe[k-1];
         prev <= pipe[DEPTH-1];
      end
   end

   assign q    = pipe[DEPTH-1];
   assign rise = q & ~prev;
   assign fall = ~q & prev;
endmodule

// File: rtl/lcd_chan.sv
module lcd_chan #(
   parameter int STAGES = 20
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              shift_en,
   input  logic              load_en,
   input  logic              dir_left,
   input  logic              in_l,
   input  logic              in_r,
   output logic [STAGES-1:0] sr_q,
   output logic [STAGES-1:0] lat_q,
   output logic              out_l,
   output logic              out_r,
   output logic              oe_l,
   output logic              oe_r
);
   always_ff @(posedge clk) begin
      if (rst) begin
         sr_q  <= '0;
         lat_q <= '0;
      end else begin
         if (shift_en)
            sr_q <= dir_left ? {in_r, sr_q[STAGES-1:1]} : {sr_q[STAGES-2:0], in_l};
         if (load_en)
            lat_q <= sr_q;
      end
   end

   assign out_l = sr_q[0];
   assign out_r = sr_q[STAGES-1];
   assign oe_l  = dir_left;
   assign oe_r  = ~dir_left;
endmodule

// File: rtl/lcd_rail_map.sv
module lcd_rail_map
   import lcd_drv_pkg::*;
#(
   parameter int STAGES = 20,
   parameter bit BANK2  = 1'b0
) (
   input  logic [STAGES-1:0]        lat,
   input  logic                     m_eff,
   output logic [STAGES*RAIL_W-1:0] rail
);
   for (genvar i = 0; i < STAGES; i++) begin : g_out
      assign rail[i*RAIL_W +: RAIL_W] = pick_rail(lat[i], m_eff, BANK2);
   end
endmodule

// File: rtl/lcd_segcom_drv.sv
module lcd_segcom_drv
   import lcd_drv_pkg::*;
#(
   parameter int STAGES      = 20,
   parameter int SYNC_DEPTH  = 2,
   parameter bit ROW_CAPABLE = 1'b1
) (
   input  logic                         clk,
   input  logic                         rst,
   input  logic                         cl1_i,
   input  logic                         cl2_i,
   input  logic                         alt_i,
   input  logic                         row_mode_i,
   input  logic [1:0]                   dir_i,
   input  logic [1:0]                   ser_l_i,
   input  logic [1:0]                   ser_r_i,
   output logic [1:0]                   ser_l_o,
   output logic [1:0]                   ser_r_o,
   output logic [1:0]                   ser_l_oe,
   output logic [1:0]                   ser_r_oe,
   output logic [2*STAGES*RAIL_W-1:0]   rail_o
);
   localparam int NCH    = 2;
   localparam int SYNC_W = 7;
   localparam int BANK_W = STAGES * RAIL_W;

   if (STAGES < 2) begin : g_bad_stages
      $error("lcd_segcom_drv: STAGES must be at least 2");
   end
   if (SYNC_DEPTH < 2) begin : g_bad_sync
      $error("lcd_segcom_drv: SYNC_DEPTH must be at least 2");
   end

   logic [SYNC_W-1:0] sy_q, sy_rise, sy_fall;
   logic [NCH-1:0]    sh_w, ld_w, m_eff;
   logic [NCH-1:0][STAGES-1:0] sr_w, lat_w;
   logic [NCH-1:0]    din_l_s, din_r_s;

   // bit order: cl1, cl2, alt, ch1 left, ch1 right, ch2 left, ch2 right
   lcd_sync_edge #(.WIDTH(SYNC_W), .DEPTH(SYNC_DEPTH)) u_sync (
      .clk (clk),
      .rst (rst),
      .d   ({ser_r_i[1], ser_l_i[1], ser_r_i[0], ser_l_i[0], alt_i, cl2_i, cl1_i}),
      .q   (sy_q),
      .rise(sy_rise),
      .fall(sy_fall)
   );

   assign din_l_s = {sy_q[5], sy_q[3]};
   assign din_r_s = {sy_q[6], sy_q[4]};

   assign sh_w[0]  = sy_fall[1];
   assign ld_w[0]  = sy_fall[0];
   assign m_eff[0] = sy_q[2];

   if (ROW_CAPABLE) begin : g_row
      assign sh_w[1]  = row_mode_i ? sy_rise[0] : sy_fall[1];
      assign ld_w[1]  = row_mode_i ? sy_rise[1] : sy_fall[0];
      assign m_eff[1] = sy_q[2] ^ row_mode_i;
   end else begin : g_seg
      logic unused_mode;
      assign unused_mode = row_mode_i;
      assign sh_w[1]  = sy_fall[1];
      assign ld_w[1]  = sy_fall[0];
      assign m_eff[1] = sy_q[2];
   end

   for (genvar c = 0; c < NCH; c++) begin : g_ch
      lcd_chan #(.STAGES(STAGES)) u_ch (
         .clk     (clk),
         .rst     (rst),
         .shift_en(sh_w[c]),
         .load_en (ld_w[c]),
         .dir_left(dir_i[c]),
         .in_l    (din_l_s[c]),
         .in_r    (din_r_s[c]),
         .sr_q    (sr_w[c]),
         .lat_q   (lat_w[c]),
         .out_l   (ser_l_o[c]),
         .out_r   (ser_r_o[c]),
         .oe_l    (ser_l_oe[c]),
         .oe_r    (ser_r_oe[c])
      );
      lcd_rail_map #(.STAGES(STAGES), .BANK2(c == 1)) u_map (
         .lat  (lat_w[c]),
         .m_eff(m_eff[c]),
         .rail (rail_o[c*BANK_W +: BANK_W])
      );
   end
endmodule

// File: rtl/lcd_segcom_chk.sv
module lcd_segcom_chk #(
   parameter int STAGES = 20
) (
   input logic                  clk,
   input logic                  rst,
   input logic [1:0]            sh,
   input logic [1:0]            ld,
   input logic [1:0]            dir,
   input logic [STAGES-1:0]     sr0,
   input logic [STAGES-1:0]     sr1,
   input logic [STAGES-1:0]     lat0,
   input logic [STAGES-1:0]     lat1,
   input logic [2*STAGES*3-1:0] rail
);
   a_r3_ch1_latch_hold: assert property (@(posedge clk) disable iff (rst)
      !ld[0] |=> $stable(lat0));
   a_r3_ch1_shift_hold: assert property (@(posedge clk) disable iff (rst)
      !sh[0] |=> $stable(sr0));
   a_r5_ch2_latch_hold: assert property (@(posedge clk) disable iff (rst)
      !ld[1] |=> $stable(lat1));
   a_r5_ch2_shift_hold: assert property (@(posedge clk) disable iff (rst)
      !sh[1] |=> $stable(sr1));
   a_r2_move_left: assert property (@(posedge clk) disable iff (rst)
      (sh[0] && dir[0]) |=> sr0[STAGES-2:0] == $past(sr0[STAGES-1:1]));
   a_r2_move_right: assert property (@(posedge clk) disable iff (rst)
      (sh[0] && !dir[0]) |=> sr0[STAGES-1:1] == $past(sr0[STAGES-2:0]));

   always @(posedge clk) begin
      if (!rst) begin
         for (int i = 0; i < 2*STAGES; i++) begin
            a_r6_rail_range: assert (rail[i*3 +: 3] >= 3'd1 && rail[i*3 +: 3] <= 3'd6);
         end
      end
   end
endmodule

bind lcd_segcom_drv lcd_segcom_chk #(.STAGES(STAGES)) u_chk (
   .clk (clk),
   .rst (rst),
   .sh  (sh_w),
   .ld  (ld_w),
   .dir (dir_i),
   .sr0 (sr_w[0]),
   .sr1 (sr_w[1]),
   .lat0(lat_w[0]),
   .lat1(lat_w[1]),
   .rail(rail_o)
);

// File: tb/tb_lcd_segcom_drv.sv
module tb_lcd_segcom_drv;
   localparam int N = 20;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic cl1 = 1'b0, cl2 = 1'b1, alt = 1'b0, row = 1'b0;
   logic [1:0] dir = 2'b01, sl = 2'b00, sr = 2'b00;
   logic [1:0] slo, sro, sloe, sroe;
   logic [2*N*3-1:0] rail;

   int checks = 0, errors = 0;
   bit started = 0, done = 0;

   always #5 clk = ~clk;

   lcd_segcom_drv dut (
      .clk(clk), .rst(rst), .cl1_i(cl1), .cl2_i(cl2), .alt_i(alt),
      .row_mode_i(row), .dir_i(dir), .ser_l_i(sl), .ser_r_i(sr),
      .ser_l_o(slo), .ser_r_o(sro), .ser_l_oe(sloe), .ser_r_oe(sroe),
      .rail_o(rail)
   );

   // behavioural reference: input history h[0] newest, registers as bit arrays
   logic [6:0] h [3];
   bit msr [2][N];
   bit mlat[2][N];

   function automatic logic [6:0] snap();
      return {sr[1], sl[1], sr[0], sl[0], alt, cl2, cl1};
   endfunction

   function automatic int exp_rail(int ch, bit b, bit m, bit md);
      bit mm;
      mm = (ch == 1) ? (m ^ md) : m;
      if (b) return mm ? 1 : 2;
      if (ch == 0) return m ? 3 : 4;
      return mm ? 5 : 6;
   endfunction

   always @(posedge clk) begin
      if (rst) begin
         for (int k = 0; k < 3; k++) h[k] = '0;
         for (int c = 0; c < 2; c++)
            for (int i = 0; i < N; i++) begin msr[c][i] = 0; mlat[c][i] = 0; end
      end else begin
         // R9: strobes act two edges after they are sampled
         bit r1, f1, r2, f2;
         bit shv [2];
         bit ldv [2];
         r1 = h[1][0] & ~h[2][0]; f1 = ~h[1][0] & h[2][0];
         r2 = h[1][1] & ~h[2][1]; f2 = ~h[1][1] & h[2][1];
         shv[0] = f2; ldv[0] = f1;
         shv[1] = row ? r1 : f2; ldv[1] = row ? r2 : f1;
         for (int c = 0; c < 2; c++) begin
            bit dl, dr;
            dl = h[1][3 + 2*c]; dr = h[1][4 + 2*c];
            if (ldv[c]) for (int i = 0; i < N; i++) mlat[c][i] = msr[c][i];
            if (shv[c]) begin
               if (dir[c]) begin
                  for (int i = 0; i < N-1; i++) msr[c][i] = msr[c][i+1];
                  msr[c][N-1] = dr;
               end else begin
                  for (int i = N-1; i > 0; i--) msr[c][i] = msr[c][i-1];
                  msr[c][0] = dl;
               end
            end
         end
         h[2] = h[1]; h[1] = h[0]; h[0] = snap();
      end
      started = 1;
   end

   task automatic chk(string tag, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
      end
   endtask

   // per-cycle comparison, away from the rising edge
   always @(negedge clk) begin
      if (started && !done) begin
         bit m;
         int bad0, bad1, e0, e1, a0, a1;
         m = rst ? 1'b0 : h[1][2];
         bad0 = 0; bad1 = 0; e0 = 0; e1 = 0; a0 = 0; a1 = 0;
         for (int i = 0; i < N; i++) begin
            int x0, x1;
            x0 = exp_rail(0, mlat[0][i], m, row);
            x1 = exp_rail(1, mlat[1][i], m, row);
            if (int'(rail[i*3 +: 3]) != x0 && !bad0) begin bad0 = 1; e0 = x0; a0 = int'(rail[i*3 +: 3]); end
            if (int'(rail[(N+i)*3 +: 3]) != x1 && !bad1) begin bad1 = 1; e1 = x1; a1 = int'(rail[(N+i)*3 +: 3]); end
         end
         chk("R3/R6 ch1 rail", a0, e0);
         if (row) chk("R5/R8 ch2 rail", a1, e1);
         else     chk("R4/R7 ch2 rail", a1, e1);
         chk("R2/R10 serial pins",
             {slo, sro, sloe, sroe},
             {msr[1][0], msr[0][0], msr[1][N-1], msr[0][N-1], dir, ~dir});
      end
   end

   task automatic wait_n(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic shift_cl2();
      cl2 = 1'b0; wait_n(5); cl2 = 1'b1; wait_n(5);
   endtask

   task automatic pulse_cl1();
      cl1 = 1'b1; wait_n(5); cl1 = 1'b0; wait_n(5);
   endtask

   task automatic load_rows(int seed);
      for (int j = 0; j < N; j++) begin
         sl = 2'((j * seed + 1) % 4);
         sr = 2'((j + seed) % 3);
         wait_n(3);
         shift_cl2();
      end
      pulse_cl1();
   endtask

   initial begin
      logic [2:0] old;
      wait_n(4);
      // R1: reset state
      chk("R1 ch1 reset code", int'(rail[2:0]), 4);
      chk("R1 ch2 reset code", int'(rail[N*3 +: 3]), 6);
      rst = 1'b0;
      wait_n(6);

      // segment mode, channel 1 moving left, channel 2 moving right
      load_rows(3);
      alt = 1'b1; wait_n(6);
      load_rows(5);

      // R9: alternation latency of two edges
      old = rail[2:0];
      alt = ~alt;
      wait_n(1);
      chk("R9 alt not yet visible", int'(rail[2:0]), int'(old));
      wait_n(1);
      checks++;
      if (rail[2:0] == old) begin
         errors++;
         $display("FAIL R9 alt visible actual=%0d expected!=%0d", rail[2:0], old);
      end

      dir = 2'b10; wait_n(6);
      load_rows(7);
      alt = 1'b0; wait_n(6);

      // R5/R8: row mode, marker walks down channel 2 once per line
      row = 1'b1; wait_n(6);
      for (int line = 0; line < 12; line++) begin
         sl = (line == 0) ? 2'b11 : 2'b01;
         sr = (line == 0) ? 2'b10 : 2'b00;
         wait_n(3);
         pulse_cl1();
         shift_cl2();
         if (line % 3 == 2) begin alt = ~alt; wait_n(4); end
      end
      dir = 2'b01; wait_n(4);
      for (int line = 0; line < 6; line++) begin
         sr = (line == 1) ? 2'b10 : 2'b01;
         wait_n(3);
         pulse_cl1();
         shift_cl2();
      end
      wait_n(10);
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         done = 1;
         checks++; errors++;
         $display("FAIL watchdog expired");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule